// File: doc/BRIEF.md
# SPI Memory Write-Protection Gate

This block sits beside the command decoder of a small SPI serial memory and rules on every write that reaches it. It keeps a write-enable latch that powers up clear, is armed by a completed write-enable command and is disarmed by a completed write-disable command or by the end of a programming cycle. A command counts as completed only when chip select returns high after exactly one full opcode byte.

Each write request targets either the memory array or the status register. The block answers it one cycle later with exactly one pulse: grant or reject. A refused request must leave memory and status untouched, and the neighbouring logic uses the reject pulse to ensure that.

Array writes are refused inside the range locked by the two block-protect bits. Status-register writes are refused while hardware protection is active, which is the case when the protect pin is low and the status protect-enable bit is set. Either kind of write is refused while the latch is clear.

Top module: `wpg_gate`

## Requirements
- R1: After reset, `wel`, `wr_grant` and `wr_reject` are all 0.
- R2: When `cs_rise` is high while `bit_cnt` equals 8 and `op_wren` is high, `wel` reads 1 from the next cycle.
- R3: A chip-select rise with `bit_cnt` other than 8 changes nothing: `wel` keeps its value whether `op_wren` or `op_wrdi` is set.
- R4: When `cs_rise` is high while `bit_cnt` equals 8 and `op_wrdi` is high, `wel` reads 0 from the next cycle.
- R5: A `cycle_done` pulse clears `wel` on the next cycle. If a completed write-enable arrives in the same cycle, the set wins and `wel` reads 1.
- R6: A write request (`wr_req`=1) made while `wel` is 0 is rejected, whatever the target and protection state.
- R7: An array write (`wr_status`=0) with `wel`=1 is rejected when its address lies in the locked range and granted otherwise. The two address MSBs are compared against `sr_bp`: 00 locks nothing, 01 locks addresses whose two MSBs are 11 (upper quarter), 10 locks addresses whose MSB is 1 (upper half), and 11 locks every address.
- R8: A status write (`wr_status`=1) with `wel`=1 is rejected when `wp_pin`=0 and `sr_wpen`=1, and is granted otherwise. The protect pin and `sr_wpen` do not affect array writes.
- R9: `wr_grant` and `wr_reject` are one-cycle pulses in the cycle after a request. Exactly one of them is high for each request, and both are 0 in the cycle after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_rise | input | 1 | Pulse: chip select has just returned high |
| bit_cnt | input | CNT_W | Number of bits clocked in during the finished transaction |
| op_wren | input | 1 | Decoded opcode is write-enable |
| op_wrdi | input | 1 | Decoded opcode is write-disable |
| cycle_done | input | 1 | Pulse: a programming cycle (array or status) has finished |
| wr_req | input | 1 | Pulse: a write wants to proceed |
| wr_status | input | 1 | 1 = the write targets the status register, 0 = the array |
| wr_addr | input | ADDR_W | Array address of the write |
| wp_pin | input | 1 | Hardware write-protect pin (low = protect) |
| sr_wpen | input | 1 | Status protect-enable bit |
| sr_bp | input | 2 | Status block-protect bits |
| wel | output | 1 | Write-enable latch, for status readback |
| wr_grant | output | 1 | Pulse: the write may proceed |
| wr_reject | output | 1 | Pulse: the write is refused |

## Verification
Two events can coincide on the latch: a write-enable command completing in the same cycle as a `cycle_done` pulse. The bench drives both in one cycle and expects `wel` to read 1 afterwards; it also checks `cycle_done` alone clearing the latch. A write request can also land in the cycle when the latch changes. That case is judged against the latch value held before the edge, which the bench checks by requesting a write in the very cycle the enable completes and expecting a reject.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  // Block-protect decode on the two address MSBs.
  function automatic logic bp_locks(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   bp_locks = 1'b0;
      2'b01:   bp_locks = (top2 == 2'b11);
      2'b10:   bp_locks = top2[1];
      default: bp_locks = 1'b1;
    endcase
  endfunction

  // Hardware protection is in force only with the pin low and the enable bit set.
  function automatic logic hw_locked(input logic wp_pin, input logic wpen);
    hw_locked = !wp_pin && wpen;
  endfunction

endpackage

// File: rtl/wpg_wel.sv
module wpg_wel #(
  parameter int CNT_W   = 5,
  parameter int OP_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_rise,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             op_wren,
  input  logic             op_wrdi,
  input  logic             cycle_done,
  output logic             wel,
  output logic             set_evt,
  output logic             clr_evt
);
  localparam logic [CNT_W-1:0] OP_CNT = CNT_W'(OP_BITS);

  logic full_cmd;

  assign full_cmd = cs_rise && (bit_cnt == OP_CNT);
  assign set_evt  = full_cmd && op_wren;
  assign clr_evt  = (full_cmd && op_wrdi) || cycle_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wel <= 1'b0;
    else if (set_evt) wel <= 1'b1;
    else if (clr_evt) wel <= 1'b0;
  end

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && op_wren && bit_cnt == OP_CNT |=> wel);

  // R4
  wel_wrdi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && op_wrdi && !op_wren && bit_cnt == OP_CNT |=> !wel);

  // R3
  wel_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && bit_cnt != OP_CNT && !cycle_done |=> $stable(wel));

  // R5
  wel_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && !set_evt |=> !wel);

endmodule

// File: rtl/wpg_judge.sv
module wpg_judge #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel,
  input  logic              wr_req,
  input  logic              wr_status,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wp_pin,
  input  logic              sr_wpen,
  input  logic [1:0]        sr_bp,
  output logic              permit,
  output logic              wr_grant,
  output logic              wr_reject
);
  import wpg_pkg::*;

  logic blk_lock;
  logic hw_lock;
  logic tgt_lock;

  assign blk_lock = bp_locks(sr_bp, wr_addr[ADDR_W-1 -: 2]);
  assign hw_lock  = hw_locked(wp_pin, sr_wpen);
  assign tgt_lock = wr_status ? hw_lock : blk_lock;
  assign permit   = wel && !tgt_lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_grant  <= 1'b0;
      wr_reject <= 1'b0;
    end else begin
      wr_grant  <= wr_req && permit;
      wr_reject <= wr_req && !permit;
    end
  end

  // R6
  no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wel |=> wr_reject && !wr_grant);

  // R7
  bp_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_status && sr_bp == 2'b11 |=> !wr_grant);

  // R8
  hw_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_status && !wp_pin && sr_wpen |=> wr_reject);

  // R9
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_grant && wr_reject));

  // R9
  no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !wr_grant && !wr_reject);

  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> $countones({wr_grant, wr_reject}) == 1);

endmodule

// File: rtl/wpg_gate.sv
module wpg_gate #(
  parameter int ADDR_W  = 9,
  parameter int CNT_W   = 5,
  parameter int OP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              op_wren,
  input  logic              op_wrdi,
  input  logic              cycle_done,
  input  logic              wr_req,
  input  logic              wr_status,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wp_pin,
  input  logic              sr_wpen,
  input  logic [1:0]        sr_bp,
  output logic              wel,
  output logic              wr_grant,
  output logic              wr_reject
);
  logic set_evt;
  logic clr_evt;
  logic permit;

  wpg_wel #(.CNT_W(CNT_W), .OP_BITS(OP_BITS)) u_wel (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
    .op_wren(op_wren), .op_wrdi(op_wrdi), .cycle_done(cycle_done),
    .wel(wel), .set_evt(set_evt), .clr_evt(clr_evt)
  );

  wpg_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk(clk), .rst_n(rst_n), .wel(wel), .wr_req(wr_req),
    .wr_status(wr_status), .wr_addr(wr_addr), .wp_pin(wp_pin),
    .sr_wpen(sr_wpen), .sr_bp(sr_bp), .permit(permit),
    .wr_grant(wr_grant), .wr_reject(wr_reject)
  );

  // R5
  set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt && clr_evt |=> wel);

  // R6
  permit_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> wel);

endmodule

// File: tb/wpg_gate_bench.sv
module wpg_gate_bench;
  localparam int ADDR_W = 9;
  localparam int CNT_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_rise = 1'b0, op_wren = 1'b0, op_wrdi = 1'b0, cycle_done = 1'b0;
  logic [CNT_W-1:0] bit_cnt = '0;
  logic wr_req = 1'b0, wr_status = 1'b0, wp_pin = 1'b1, sr_wpen = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [1:0] sr_bp = 2'b00;
  logic wel, wr_grant, wr_reject;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  wpg_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OP_BITS(8)) u_wpg_gate (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
    .op_wren(op_wren), .op_wrdi(op_wrdi), .cycle_done(cycle_done),
    .wr_req(wr_req), .wr_status(wr_status), .wr_addr(wr_addr),
    .wp_pin(wp_pin), .sr_wpen(sr_wpen), .sr_bp(sr_bp),
    .wel(wel), .wr_grant(wr_grant), .wr_reject(wr_reject)
  );

  // Vector: {bp[1:0], wpen, wp, is_status, addr[8:0], expect_grant}
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b1, 1'b0, 9'h1FF, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b0, 9'h17F, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b0, 9'h180, 1'b0},
    {2'b10, 1'b0, 1'b1, 1'b0, 9'h0FF, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b0, 9'h100, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b0, 9'h000, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b1, 9'h000, 1'b0},
    {2'b00, 1'b1, 1'b1, 1'b1, 9'h000, 1'b1},
    {2'b00, 1'b0, 1'b0, 1'b1, 9'h000, 1'b1},
    {2'b00, 1'b1, 1'b0, 1'b0, 9'h000, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b1, 9'h000, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Finished command at chip-select rise; drive after negedge, release after next.
  task automatic cmd(input logic wren, input logic wrdi, input int bits, input logic done);
    @(negedge clk);
    cs_rise = 1'b1; op_wren = wren; op_wrdi = wrdi; bit_cnt = CNT_W'(bits); cycle_done = done;
    @(negedge clk);
    cs_rise = 1'b0; op_wren = 1'b0; op_wrdi = 1'b0; bit_cnt = '0; cycle_done = 1'b0;
  endtask

  task automatic write(input logic st, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    wr_req = 1'b1; wr_status = st; wr_addr = a;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 wel", wel, 1'b0);
    check("R1 grant", wr_grant, 1'b0);
    check("R1 reject", wr_reject, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 write with latch clear is refused
    write(1'b0, 9'h000);
    check("R6 reject", wr_reject, 1'b1);
    check("R6 grant", wr_grant, 1'b0);

    // R3 partial commands do nothing
    cmd(1'b1, 1'b0, 7, 1'b0);
    check("R3 wren 7 bits", wel, 1'b0);
    cmd(1'b1, 1'b0, 9, 1'b0);
    check("R3 wren 9 bits", wel, 1'b0);

    // R2 full write-enable sets latch
    cmd(1'b1, 1'b0, 8, 1'b0);
    check("R2 wel set", wel, 1'b1);

    // R3 partial disable leaves latch set
    cmd(1'b0, 1'b1, 4, 1'b0);
    check("R3 wrdi 4 bits", wel, 1'b1);

    // R7 R8 vector table walk with latch set
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sr_bp = VEC[i][14:13]; sr_wpen = VEC[i][12]; wp_pin = VEC[i][11];
      wr_status = VEC[i][10]; wr_addr = VEC[i][9:1]; wr_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0;
      check(VEC[i][10] ? "R8 grant" : "R7 grant", wr_grant, VEC[i][0]);
      check(VEC[i][10] ? "R8 reject" : "R7 reject", wr_reject, !VEC[i][0]);
      @(negedge clk);
      // R9 pulses last one cycle
      check("R9 grant drop", wr_grant, 1'b0);
      check("R9 reject drop", wr_reject, 1'b0);
    end
    sr_bp = 2'b00; sr_wpen = 1'b0; wp_pin = 1'b1;

    // R4 full write-disable clears
    cmd(1'b0, 1'b1, 8, 1'b0);
    check("R4 wel clear", wel, 1'b0);

    // R5 cycle_done clears
    cmd(1'b1, 1'b0, 8, 1'b0);
    check("R5 rearm", wel, 1'b1);
    @(negedge clk); cycle_done = 1'b1;
    @(negedge clk); cycle_done = 1'b0;
    check("R5 done clears", wel, 1'b0);

    // R5 set wins over simultaneous cycle_done; R6 same-cycle write sees old latch
    @(negedge clk);
    cs_rise = 1'b1; op_wren = 1'b1; bit_cnt = 5'd8; cycle_done = 1'b1;
    wr_req = 1'b1; wr_status = 1'b0; wr_addr = 9'h000;
    @(negedge clk);
    cs_rise = 1'b0; op_wren = 1'b0; bit_cnt = '0; cycle_done = 1'b0; wr_req = 1'b0;
    check("R5 set wins", wel, 1'b1);
    check("R6 old latch reject", wr_reject, 1'b1);

    // R9 idle gives no pulses
    @(negedge clk);
    check("R9 idle grant", wr_grant, 1'b0);
    check("R9 idle reject", wr_reject, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule